// File: doc/BRIEF.md
# Resize Coefficient Calculator

This block turns a pair of image dimensions (input and output size, for both the vertical and the horizontal direction) into the control word that a downstream scaler uses. For each direction it works out how many times the input must first be halved, between zero and two times. It then computes a fixed-point step that is the ratio of the remaining input span to the output span, scaled by 2^13. The two per-direction results are packed into one 32-bit word.

A request starts with a one-cycle `start_i` while the unit is idle. At that moment the unit captures all four sizes. A small state machine then walks through the states IDLE, CHECK, DIVIDE, STORE and FINISH. CHECK validates the sizes of the current direction and either loads the divider or aborts. DIVIDE waits for an iterative restoring divider that produces one quotient bit per clock. STORE saturates and stores the step, then either switches to the horizontal direction (STORE→CHECK) or completes (STORE→FINISH). FINISH raises `done_o` for one cycle and returns to IDLE. The other transitions are IDLE→CHECK on start, CHECK→DIVIDE for a legal direction, CHECK→FINISH for an illegal one, and DIVIDE→STORE when the divider completes.

The vertical direction is processed first. Any illegal size in either direction ends the request with `err_o` set and a zero word.

Top module: `rsz_coef_calc`

## Requirements
- R1: An input size greater than 4096, or an output size greater than 1024, in either direction ends the request with err_o=1 and word_o=0.
- R2: An output size whose fourfold value is below the input size (downscaling beyond 4:1) is an error; exactly 4:1 is legal.
- R3: An output size of 0 or 1, or an input size of 0, is an error.
- R4: The halving count starts at 0. While the working size is above 1024, or at least twice the output size, and the count is below 2, the working size is halved (rounded down) and the count incremented.
- R5: The step equals floor(8192 × (working size − 1) / (output size − 1)).
- R6: A step of 16384 or more is replaced by 0x3FFF.
- R7: word_o holds the vertical halving count in bits [31:30], the vertical step in [29:16], the horizontal halving count in [15:14] and the horizontal step in [13:0].
- R8: The vertical direction is evaluated before the horizontal one. An error in either direction produces err_o=1 with word_o=0, and a fully legal request produces err_o=0.
- R9: done_o is high for exactly one cycle per request. word_o and err_o change only in the cycle done_o rises and hold until the next completion.
- R10: Sizes are captured in the cycle start_i is accepted (busy_o low). Later changes on the size inputs, and start_i pulses while busy_o is high, do not affect the result.
- R11: After reset, busy_o=0, done_o=0, err_o=0 and word_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, accepted only while idle |
| in_v_i | input | 13 | Vertical input size |
| out_v_i | input | 11 | Vertical output size |
| in_h_i | input | 13 | Horizontal input size |
| out_h_i | input | 11 | Horizontal output size |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last request had an illegal size |
| word_o | output | 32 | Packed resize-control word |

## Verification
A wrong halving count or a corrupted divider remainder shows up as a wrong field in word_o at the very next done_o pulse. Each request is therefore compared field by field against a bench model. A state machine that skips the horizontal pass or misroutes an error shows up as a wrong err_o/word_o pair at the same pulse. A capture fault, or a fault in start gating, only becomes visible when the size inputs or start_i change mid-request. The bench deliberately does both. Output holding faults show up in the idle cycles after a pulse, where the word is sampled again.

// File: rtl/rsz_pkg.sv
package rsz_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_DIVIDE,
        ST_STORE,
        ST_FINISH
    } rsz_state_e;

    typedef enum logic {
        DIR_VERT,
        DIR_HORZ
    } rsz_dir_e;

endpackage

// File: rtl/rsz_limit_chk.sv
// Combinational legality test for one direction's size pair.
module rsz_limit_chk #(
    parameter int IN_W    = 13,
    parameter int OUT_W   = 11,
    parameter int MAX_IN  = 4096,
    parameter int MAX_OUT = 1024,
    parameter int RATIO   = 4
) (
    input  logic [IN_W-1:0]  in_size,
    input  logic [OUT_W-1:0] out_size,
    output logic             illegal
);
    localparam logic [31:0] LIM_IN  = 32'(MAX_IN);
    localparam logic [31:0] LIM_OUT = 32'(MAX_OUT);
    localparam logic [31:0] LIM_RAT = 32'(RATIO);

    logic [31:0] in_x, out_x;

    always_comb begin
        in_x    = 32'(in_size);
        out_x   = 32'(out_size);
        illegal = 1'b0;
        if (in_x == 32'd0 || in_x > LIM_IN)
            illegal = 1'b1;
        if (out_x < 32'd2 || out_x > LIM_OUT)
            illegal = 1'b1;
        if (out_x * LIM_RAT < in_x)
            illegal = 1'b1;
    end
endmodule

// File: rtl/rsz_prescale.sv
// Chain of conditional halving stages; one generate slice per stage.
module rsz_prescale #(
    parameter int IN_W    = 13,
    parameter int OUT_W   = 11,
    parameter int MAX_OUT = 1024,
    parameter int STAGES  = 2,
    parameter int STAGE_W = 2
) (
    input  logic [IN_W-1:0]    in_size,
    input  logic [OUT_W-1:0]   out_size,
    output logic [IN_W-1:0]    work_size,
    output logic [STAGE_W-1:0] stage_cnt
);
    localparam logic [31:0] LIM_OUT = 32'(MAX_OUT);

    logic [IN_W-1:0]    sz  [0:STAGES];
    logic [STAGE_W-1:0] cnt [0:STAGES];
    logic [31:0]        twice_out;

    assign twice_out = 32'(out_size) << 1;
    assign sz[0]     = in_size;
    assign cnt[0]    = '0;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic halve;
        assign halve      = (32'(sz[g]) > LIM_OUT) || (32'(sz[g]) >= twice_out);
        assign sz[g+1]    = halve ? (sz[g] >> 1) : sz[g];
        assign cnt[g+1]   = halve ? cnt[g] + STAGE_W'(1) : cnt[g];
    end

    assign work_size = sz[STAGES];
    assign stage_cnt = cnt[STAGES];
endmodule

// File: rtl/rsz_div.sv
// Restoring divider, one quotient bit per clock.
module rsz_div #(
    parameter int NUM_W = 26,
    parameter int DEN_W = 11
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic [NUM_W-1:0] quo_o,
    output logic             done_o
);
    localparam int CNT_W = $clog2(NUM_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_W - 1);

    logic [DEN_W-1:0] rem_q, den_q;
    logic [NUM_W-1:0] quo_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q, done_q;
    logic [DEN_W:0]   trial;
    logic             fits;

    assign trial = {rem_q, quo_q[NUM_W-1]};
    assign fits  = trial >= {1'b0, den_q};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rem_q  <= '0;
            den_q  <= '0;
            quo_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load_i) begin
                rem_q <= '0;
                den_q <= den_i;
                quo_q <= num_i;
                cnt_q <= '0;
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
                quo_q <= {quo_q[NUM_W-2:0], fits};
                cnt_q <= cnt_q + CNT_W'(1);
                if (cnt_q == LAST) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign quo_o  = quo_q;
    assign done_o = done_q;
endmodule

// File: rtl/rsz_coef_calc.sv
module rsz_coef_calc
    import rsz_pkg::*;
#(
    parameter int IN_W    = 13,
    parameter int OUT_W   = 11,
    parameter int MAX_IN  = 4096,
    parameter int MAX_OUT = 1024,
    parameter int RATIO   = 4,
    parameter int FRAC_W  = 13,
    parameter int STEP_W  = 14,
    parameter int STAGES  = 2,
    parameter int STAGE_W = 2
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic                              start_i,
    input  logic [IN_W-1:0]                   in_v_i,
    input  logic [OUT_W-1:0]                  out_v_i,
    input  logic [IN_W-1:0]                   in_h_i,
    input  logic [OUT_W-1:0]                  out_h_i,
    output logic                              busy_o,
    output logic                              done_o,
    output logic                              err_o,
    output logic [2*(STEP_W+STAGE_W)-1:0]     word_o
);
    localparam int HALF_W = STEP_W + STAGE_W;
    localparam int WORD_W = 2 * HALF_W;
    localparam int NUM_W  = IN_W + FRAC_W;

    rsz_state_e state_q, state_d;
    rsz_dir_e   dir_q;

    logic [IN_W-1:0]    cap_in_v_q, cap_in_h_q, cur_in;
    logic [OUT_W-1:0]   cap_out_v_q, cap_out_h_q, cur_out;
    logic               cur_bad;
    logic [IN_W-1:0]    work;
    logic [STAGE_W-1:0] stage;
    logic               div_load, div_done;
    logic [NUM_W-1:0]   div_num, div_quo;
    logic [OUT_W-1:0]   div_den;
    logic [STEP_W-1:0]  step_sat;
    logic [HALF_W-1:0]  vert_q;
    logic [WORD_W-1:0]  word_q;
    logic               err_q;

    assign cur_in  = (dir_q == DIR_VERT) ? cap_in_v_q  : cap_in_h_q;
    assign cur_out = (dir_q == DIR_VERT) ? cap_out_v_q : cap_out_h_q;

    rsz_limit_chk #(
        .IN_W(IN_W), .OUT_W(OUT_W), .MAX_IN(MAX_IN),
        .MAX_OUT(MAX_OUT), .RATIO(RATIO)
    ) u_limit (
        .in_size (cur_in),
        .out_size(cur_out),
        .illegal (cur_bad)
    );

    rsz_prescale #(
        .IN_W(IN_W), .OUT_W(OUT_W), .MAX_OUT(MAX_OUT),
        .STAGES(STAGES), .STAGE_W(STAGE_W)
    ) u_pre (
        .in_size  (cur_in),
        .out_size (cur_out),
        .work_size(work),
        .stage_cnt(stage)
    );

    assign div_num  = {work - IN_W'(1), {FRAC_W{1'b0}}};
    assign div_den  = cur_out - OUT_W'(1);
    assign div_load = (state_q == ST_CHECK) && !cur_bad;

    rsz_div #(.NUM_W(NUM_W), .DEN_W(OUT_W)) u_div (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .load_i(div_load),
        .num_i (div_num),
        .den_i (div_den),
        .quo_o (div_quo),
        .done_o(div_done)
    );

    // Saturate an overlong quotient to all ones in the step field.
    assign step_sat = (|div_quo[NUM_W-1:STEP_W]) ? {STEP_W{1'b1}} : div_quo[STEP_W-1:0];

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i)  state_d = ST_CHECK;
            ST_CHECK:  state_d = cur_bad ? ST_FINISH : ST_DIVIDE;
            ST_DIVIDE: if (div_done) state_d = ST_STORE;
            ST_STORE:  state_d = (dir_q == DIR_VERT) ? ST_CHECK : ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Datapath and output registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dir_q       <= DIR_VERT;
            cap_in_v_q  <= '0;
            cap_out_v_q <= '0;
            cap_in_h_q  <= '0;
            cap_out_h_q <= '0;
            vert_q      <= '0;
            word_q      <= '0;
            err_q       <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        dir_q       <= DIR_VERT;
                        cap_in_v_q  <= in_v_i;
                        cap_out_v_q <= out_v_i;
                        cap_in_h_q  <= in_h_i;
                        cap_out_h_q <= out_h_i;
                    end
                end
                ST_CHECK: begin
                    if (cur_bad) begin
                        word_q <= '0;
                        err_q  <= 1'b1;
                    end
                end
                ST_STORE: begin
                    if (dir_q == DIR_VERT) begin
                        vert_q <= {stage, step_sat};
                        dir_q  <= DIR_HORZ;
                    end else begin
                        word_q <= {vert_q, stage, step_sat};
                        err_q  <= 1'b0;
                    end
                end
                ST_DIVIDE, ST_FINISH: begin
                end
                default: begin
                end
            endcase
        end
    end

    assign busy_o = (state_q != ST_IDLE) && (state_q != ST_FINISH);
    assign done_o = (state_q == ST_FINISH);
    assign err_o  = err_q;
    assign word_o = word_q;
endmodule

// File: rtl/rsz_coef_calc_chk.sv
module rsz_coef_calc_chk #(
    parameter int STEP_W  = 14,
    parameter int STAGE_W = 2
) (
    input logic                          clk_i,
    input logic                          rst_ni,
    input logic                          start_i,
    input logic                          busy_o,
    input logic                          done_o,
    input logic                          err_o,
    input logic [2*(STEP_W+STAGE_W)-1:0] word_o
);
    localparam int HALF_W = STEP_W + STAGE_W;
    localparam int WORD_W = 2 * HALF_W;

    // R9
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R9
    word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> ($stable(word_o) && $stable(err_o)));

    // R8
    err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && err_o) |-> (word_o == '0));

    // R4
    stage_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !err_o) |->
            ((word_o[WORD_W-1 -: STAGE_W] <= STAGE_W'(2)) &&
             (word_o[HALF_W-1 -: STAGE_W] <= STAGE_W'(2))));

    // R10
    busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(start_i));

    // R10
    busy_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> (busy_o || done_o));
endmodule

bind rsz_coef_calc rsz_coef_calc_chk #(.STEP_W(STEP_W), .STAGE_W(STAGE_W)) chk_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .busy_o (busy_o),
    .done_o (done_o),
    .err_o  (err_o),
    .word_o (word_o)
);

// File: tb/rsz_coef_calc_tb.sv
module rsz_coef_calc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [12:0] in_v = '0, in_h = '0;
    logic [10:0] out_v = '0, out_h = '0;
    logic        busy, done, err;
    logic [31:0] word;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    rsz_coef_calc dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .in_v_i(in_v), .out_v_i(out_v), .in_h_i(in_h), .out_h_i(out_h),
        .busy_o(busy), .done_o(done), .err_o(err), .word_o(word)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Model of one direction: returns {stage, step}, flags illegal pairs (R1-style rules)
    function automatic int half_model(input int si, input int so, output bit bad);
        int w, st;
        longint q;
        bad = (si == 0) || (si > 4096) || (so < 2) || (so > 1024) || (so * 4 < si);
        if (bad) return 0;
        w = si; st = 0;
        while ((w > 1024 || w >= 2 * so) && st < 2) begin
            w = w >> 1;
            st++;
        end
        q = (64'd8192 * longint'(w - 1)) / longint'(so - 1);
        if (q >= 16384) q = 16'h3FFF;
        return (st << 14) | int'(q);
    endfunction

    task automatic run(input int iv, input int ov, input int ih, input int oh,
                       input bit disturb, input string tag);
        bit bv, bh, eb;
        int hv, hh, n;
        logic [31:0] ew;
        hv = half_model(iv, ov, bv);
        hh = half_model(ih, oh, bh);
        eb = bv || bh;
        ew = eb ? 32'd0 : {hv[15:0], hh[15:0]};
        @(negedge clk);
        in_v = 13'(iv); out_v = 11'(ov); in_h = 13'(ih); out_h = 11'(oh);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            // R10: change inputs after capture and pulse start while busy
            in_v = 13'd4000; out_v = 11'd2; in_h = 13'd7; out_h = 11'd1000;
            @(negedge clk);
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!done && n < 400) begin
            @(negedge clk);
            n++;
        end
        if (!done) check({tag, " R9 done timeout"}, 0, 1);
        check({tag, " R7 word"}, word, ew);
        check({tag, " R8 err"}, err, eb);
        @(negedge clk);
        check({tag, " R9 single-cycle done"}, done, 0);
        @(negedge clk);
        @(negedge clk);
        check({tag, " R9 word held"}, word, ew);
    endtask

    initial begin
        #(8 * 190000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d2c));
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 busy", busy, 0);
        check("R11 done", done, 0);
        check("R11 err", err, 0);
        check("R11 word", word, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run(4097, 1024, 100, 100, 0, "R1 input too big");
        run(100, 100, 2000, 1025, 0, "R1 output too big");
        run(401, 100, 100, 100, 0, "R2 beyond 4:1");
        run(400, 100, 400, 100, 0, "R2 exact 4:1");
        run(100, 1, 100, 100, 0, "R3 output one");
        run(0, 10, 10, 10, 0, "R3 input zero");
        run(4096, 1024, 4096, 1024, 0, "R4 forced halving");
        run(1000, 250, 2, 2, 0, "R4 stage cap");
        run(2, 1024, 3, 2, 0, "R6 saturation");
        run(1000, 600, 37, 19, 0, "R5 step");
        run(100, 100, 100, 0, 0, "R8 horizontal error");
        run(640, 480, 1920, 720, 1, "R10 ignore start");
        run(300, 301, 123, 45, 0, "R7 packing");

        for (int i = 0; i < 300; i++) begin
            int ov, oh, iv, ih;
            ov = 2 + int'($urandom % 1023);
            oh = 2 + int'($urandom % 1023);
            iv = 1 + int'($urandom % ((ov * 4 > 4096) ? 4096 : ov * 4));
            ih = 1 + int'($urandom % ((oh * 4 > 4096) ? 4096 : oh * 4));
            if ($urandom % 8 == 0) ih = int'($urandom % 5000);
            run(iv, ov, ih, oh, ($urandom % 10) == 0, "R5 random");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule